// File: doc/BRIEF.md
# Discontinuous Receive Wake-Up Sequencer

This block paces a radio receiver that saves power by listening only part of the time. When discontinuous operation is enabled, it steps through a fixed cycle of phases. First comes a powered-down off phase. Next is a recovery phase that gives the host processor time to wake, still at low power. Then comes a settle phase, where the RF section is powered but the peak detectors and data outputs stay gated. Last is a listen phase with everything enabled. After listening, the cycle returns to the off phase.

The off phase length is a 16-bit count built from two byte inputs. Each count unit is a time base of 1, 4, 16 or 64 reference ticks, picked by a two-bit prescale code. The recovery length is one byte and the settle length is 16 bits, both counted in reference ticks. The listen window lasts 256 ticks. A valid-data indication holds the block in listen for as long as it is asserted. During recovery or settle, the host can pull the shared data line low to abort the wake-up and restart from the off phase. When discontinuous operation is disabled, the block falls back to continuous receive with every enable high.

Top module: `drx_wake_seq`

## Requirements
- R1: While rst_ni is low and directly after it, phase_o reads 0 (off) and rf_pwr_o, peak_en_o and dout_en_o are all low.
- R2: One clock after drx_en_i is sampled low, phase_o reads 4 (continuous) and all three enables are high, whatever the phase was.
- R3: With drx_en_i high and the off count {off_hi_i, off_lo_i} equal to zero, the block stays in phase 0 indefinitely.
- R4: The off phase lasts {off_hi_i, off_lo_i} times the time base, counted in tick_i pulses. The time base is 1, 4, 16 or 64 ticks for prescale_i = 0, 1, 2 or 3.
- R5: Phases run in the order off (0), recovery (1), settle (2), listen (3). Recovery lasts max(rec_len_i, 1) ticks and settle lasts max({settle_hi_i, settle_lo_i}, 1) ticks.
- R6: In phases 0 and 1 all enables are low. In phase 2 only rf_pwr_o is high. In phase 3 all three enables are high.
- R7: data_i sampled low during phase 1 or 2 moves the block to phase 0 on the next clock, and the full off count starts again.
- R8: data_i low during phases 0 and 3 has no effect on phase timing.
- R9: Listen returns to phase 0 after 256 ticks with valid_i low. While valid_i is high, the block stays in phase 3 and its window restarts.
- R10: Without tick_i pulses, no phase advances except through R2 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| drx_en_i | input | 1 | Discontinuous mode enable; low selects continuous receive |
| tick_i | input | 1 | Reference tick pulse, one clock wide |
| prescale_i | input | 2 | Off-phase time base select |
| off_hi_i | input | 8 | Off count upper byte |
| off_lo_i | input | 8 | Off count lower byte |
| rec_len_i | input | 8 | Host recovery length in ticks |
| settle_hi_i | input | 8 | Settle length upper byte |
| settle_lo_i | input | 8 | Settle length lower byte |
| data_i | input | 1 | Shared data line; low aborts recovery or settle |
| valid_i | input | 1 | Valid-data stub; holds listen |
| rf_pwr_o | output | 1 | RF section power enable |
| peak_en_o | output | 1 | Peak detector enable |
| dout_en_o | output | 1 | Data output enable |
| phase_o | output | 3 | Current phase code (0 off, 1 recovery, 2 settle, 3 listen, 4 continuous) |

## Verification
The bench measures exact phase lengths under two prescale codes. An off-by-one in the time base or in the byte concatenation would show as an off phase of 8 or 16 cycles instead of 12, or 64 instead of 128. The data line is pulled low in the middle of recovery and also during the off phase. A design that ignored the abort would carry on into settle, and one that honoured the line everywhere would cut the off phase short. Three more cases are driven: a zero off count, a long valid-data hold, and a stretch with no reference ticks. These catch a sequencer that starts cycling unprogrammed, drops out of listen on time regardless of valid data, or counts clocks instead of ticks.

// File: rtl/drx_pkg.sv
package drx_pkg;
  typedef enum logic [2:0] {
    PH_OFF    = 3'd0,
    PH_REC    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_LISTEN = 3'd3,
    PH_CONT   = 3'd4
  } phase_e;
endpackage

// File: rtl/drx_prescaler.sv
module drx_prescaler #(
  parameter int SEL_W = 2,
  parameter int STEP  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             base_o
);
  localparam int PRE_W = STEP * ((1 << SEL_W) - 1);

  logic [PRE_W-1:0] pre_q, lim;

  always_comb lim = PRE_W'((32'd1 << (STEP * 32'(sel_i))) - 32'd1);

  // >= keeps the counter bounded if sel_i shrinks mid-count
  assign base_o = en_i && tick_i && (pre_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (clr_i)             pre_q <= '0;
    else if (en_i && tick_i)    pre_q <= (pre_q >= lim) ? '0 : pre_q + 1'b1;
  end

  a_r4_base_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_o && !clr_i) |=> (pre_q == '0));
  a_r4_base_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/drx_phase_fsm.sv
module drx_phase_fsm
  import drx_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int LISTEN_TICKS = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             drx_en_i,
  input  logic             tick_i,
  input  logic             base_i,
  input  logic             data_i,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] off_val_i,
  input  logic [CNT_W-1:0] rec_val_i,
  input  logic [CNT_W-1:0] settle_val_i,
  output logic             off_run_o,
  output phase_e           phase_o
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] LISTEN_LIM = CW'(LISTEN_TICKS);

  phase_e phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc   = CW'(cnt_q) + CW'(1);
  assign off_run_o = (phase_q == PH_OFF) && (off_val_i != '0);
  assign phase_o   = phase_q;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!drx_en_i) begin
      phase_d = PH_CONT;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_CONT: begin
          phase_d = PH_OFF;
          cnt_d   = '0;
        end
        PH_OFF: if (base_i) begin
          if (cnt_inc >= CW'(off_val_i)) begin phase_d = PH_REC; cnt_d = '0; end
          else cnt_d = cnt_inc[CNT_W-1:0];
        end
        PH_REC: begin
          if (!data_i) begin phase_d = PH_OFF; cnt_d = '0; end
          else if (tick_i) begin
            if (cnt_inc >= CW'(rec_val_i)) begin phase_d = PH_SETTLE; cnt_d = '0; end
            else cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        PH_SETTLE: begin
          if (!data_i) begin phase_d = PH_OFF; cnt_d = '0; end
          else if (tick_i) begin
            if (cnt_inc >= CW'(settle_val_i)) begin phase_d = PH_LISTEN; cnt_d = '0; end
            else cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        PH_LISTEN: begin
          if (valid_i) cnt_d = '0;
          else if (tick_i) begin
            if (cnt_inc >= LISTEN_LIM) begin phase_d = PH_OFF; cnt_d = '0; end
            else cnt_d = cnt_inc[CNT_W-1:0];
          end
        end
        default: begin phase_d = PH_OFF; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_OFF;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  a_r2_cont: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drx_en_i |=> (phase_q == PH_CONT));
  a_r3_zero_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drx_en_i && phase_q == PH_OFF && off_val_i == '0) |=> (phase_q == PH_OFF));
  a_r5_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(phase_q) != PH_SETTLE && phase_q == PH_SETTLE) |-> ($past(phase_q) == PH_REC));
  a_r7_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drx_en_i && !data_i && (phase_q == PH_REC || phase_q == PH_SETTLE))
      |=> (phase_q == PH_OFF && cnt_q == '0));
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drx_en_i && valid_i && phase_q == PH_LISTEN) |=> (phase_q == PH_LISTEN));
  a_r10_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drx_en_i && !tick_i && data_i && phase_q != PH_CONT) |=> $stable(phase_q));
endmodule

// File: rtl/drx_out_decode.sv
module drx_out_decode
  import drx_pkg::*;
(
  input  phase_e phase_i,
  output logic   rf_pwr_o,
  output logic   peak_en_o,
  output logic   dout_en_o
);
  always_comb begin
    rf_pwr_o  = 1'b0;
    peak_en_o = 1'b0;
    dout_en_o = 1'b0;
    unique case (phase_i)
      PH_SETTLE: rf_pwr_o = 1'b1;
      PH_LISTEN, PH_CONT: begin
        rf_pwr_o  = 1'b1;
        peak_en_o = 1'b1;
        dout_en_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/drx_wake_seq.sv
module drx_wake_seq
  import drx_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int SEL_W        = 2,
  parameter int STEP         = 2,
  parameter int LISTEN_TICKS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drx_en_i,
  input  logic              tick_i,
  input  logic [SEL_W-1:0]  prescale_i,
  input  logic [BYTE_W-1:0] off_hi_i,
  input  logic [BYTE_W-1:0] off_lo_i,
  input  logic [BYTE_W-1:0] rec_len_i,
  input  logic [BYTE_W-1:0] settle_hi_i,
  input  logic [BYTE_W-1:0] settle_lo_i,
  input  logic              data_i,
  input  logic              valid_i,
  output logic              rf_pwr_o,
  output logic              peak_en_o,
  output logic              dout_en_o,
  output logic [2:0]        phase_o
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0] off_val, rec_val, settle_val;
  logic off_run, base;
  phase_e phase;

  assign off_val    = {off_hi_i, off_lo_i};
  assign settle_val = {settle_hi_i, settle_lo_i};
  assign rec_val    = CNT_W'(rec_len_i);

  drx_prescaler #(.SEL_W(SEL_W), .STEP(STEP)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase != PH_OFF),
    .en_i   (off_run),
    .tick_i (tick_i),
    .sel_i  (prescale_i),
    .base_o (base)
  );

  drx_phase_fsm #(.CNT_W(CNT_W), .LISTEN_TICKS(LISTEN_TICKS)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .drx_en_i     (drx_en_i),
    .tick_i       (tick_i),
    .base_i       (base),
    .data_i       (data_i),
    .valid_i      (valid_i),
    .off_val_i    (off_val),
    .rec_val_i    (rec_val),
    .settle_val_i (settle_val),
    .off_run_o    (off_run),
    .phase_o      (phase)
  );

  drx_out_decode u_dec (
    .phase_i   (phase),
    .rf_pwr_o  (rf_pwr_o),
    .peak_en_o (peak_en_o),
    .dout_en_o (dout_en_o)
  );

  assign phase_o = phase;

  a_r6_peak_needs_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peak_en_o |-> rf_pwr_o);
  a_r6_gates_paired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o == peak_en_o);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!rf_pwr_o && !peak_en_o && !dout_en_o));
endmodule

// File: tb/sim_drx_wake_seq.sv
module sim_drx_wake_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic drx_en = 1'b1, tick = 1'b1, data = 1'b1, valid = 1'b0;
  logic [1:0] ps = 2'd1;
  logic [7:0] off_hi = 8'd0, off_lo = 8'd0, rec_len = 8'd5, set_hi = 8'd0, set_lo = 8'd7;
  logic rf, peak, dout;
  logic [2:0] phase;
  int checks = 0, errors = 0, n;

  always #5 clk = ~clk;

  drx_wake_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .drx_en_i(drx_en), .tick_i(tick), .prescale_i(ps),
    .off_hi_i(off_hi), .off_lo_i(off_lo), .rec_len_i(rec_len), .settle_hi_i(set_hi),
    .settle_lo_i(set_lo), .data_i(data), .valid_i(valid),
    .rf_pwr_o(rf), .peak_en_o(peak), .dout_en_o(dout), .phase_o(phase)
  );

  // behavioural reference: integers only
  int m_ph = 0, m_cnt = 0, m_pre = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_ph = 0; m_cnt = 0; m_pre = 0; end
    else begin
      int offv, setv, base, np, nc;
      bit fire;
      offv = {off_hi, off_lo}; setv = {set_hi, set_lo};
      base = 1 << (2 * ps);
      fire = 0;
      if (m_ph != 0) m_pre = 0;
      else if (offv != 0 && tick) begin
        m_pre = m_pre + 1;
        if (m_pre >= base) begin m_pre = 0; fire = 1; end
      end
      np = m_ph; nc = m_cnt;
      if (!drx_en) begin np = 4; nc = 0; end
      else case (m_ph)
        4: begin np = 0; nc = 0; end
        0: if (fire) begin nc = m_cnt + 1; if (nc >= offv) begin np = 1; nc = 0; end end
        1, 2: if (!data) begin np = 0; nc = 0; end
              else if (tick) begin
                nc = m_cnt + 1;
                if (nc >= ((m_ph == 1) ? rec_len : setv)) begin np = m_ph + 1; nc = 0; end
              end
        3: if (valid) nc = 0;
           else if (tick) begin nc = m_cnt + 1; if (nc >= 256) begin np = 0; nc = 0; end end
        default: ;
      endcase
      m_ph = np; m_cnt = nc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    chk("R5 phase vs model", int'(phase), m_ph);
    chk("R6 enables vs model", int'({rf, peak, dout}),
        (m_ph == 2) ? 4 : (m_ph >= 3) ? 7 : 0);
  end

  task automatic measure(input logic [2:0] p, output int len);
    len = 0;
    while (phase != p) @(negedge clk);
    while (phase == p) begin len++; @(negedge clk); end
  endtask

  task automatic restart();
    drx_en = 1'b0; @(negedge clk);
    drx_en = 1'b1;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset enables", int'({rf, peak, dout}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", int'({rf, peak, dout}), 0);
    // R3: zero off count holds
    repeat (40) @(negedge clk);
    chk("R3 zero count idle", int'(phase), 0);
    // R2: continuous receive
    drx_en = 1'b0; @(negedge clk);
    chk("R2 cont phase", int'(phase), 4);
    chk("R2 cont enables", int'({rf, peak, dout}), 7);
    off_lo = 8'd3; drx_en = 1'b1;
    measure(3'd0, n); chk("R4 off 3 x base 4", n, 12);
    measure(3'd1, n); chk("R5 recovery length", n, 5);
    chk("R6 settle gating", int'({rf, peak, dout}), 4);
    measure(3'd2, n); chk("R5 settle length", n, 7);
    measure(3'd3, n); chk("R9 listen window", n, 256);
    // R8: data low in off and listen is ignored
    data = 1'b0;
    measure(3'd0, n); chk("R8 off unaffected", n, 12);
    data = 1'b1;
    // R7: abort during recovery
    while (phase != 3'd1) @(negedge clk);
    @(negedge clk);
    data = 1'b0; @(negedge clk);
    chk("R7 abort to off", int'(phase), 0);
    data = 1'b1;
    measure(3'd0, n); chk("R7 full off after abort", n, 12);
    // R7: abort during settle
    while (phase != 3'd2) @(negedge clk);
    data = 1'b0; @(negedge clk);
    chk("R7 settle abort", int'(phase), 0);
    data = 1'b1;
    // R9: valid holds listen
    while (phase != 3'd3) @(negedge clk);
    valid = 1'b1;
    repeat (400) @(negedge clk);
    chk("R9 valid holds listen", int'(phase), 3);
    valid = 1'b0;
    measure(3'd3, n); chk("R9 window restarts", n, 256);
    // R10: no ticks, no progress
    while (phase != 3'd1) @(negedge clk);
    tick = 1'b0;
    repeat (50) @(negedge clk);
    chk("R10 recovery frozen", int'(phase), 1);
    tick = 1'b1;
    // R4: prescale 3, count 2
    while (phase != 3'd3) @(negedge clk);
    ps = 2'd3; off_lo = 8'd2;
    measure(3'd0, n); chk("R4 off 2 x base 64", n, 128);
    // R4: upper byte weight via prescale 0
    ps = 2'd0; off_hi = 8'd1; off_lo = 8'd0;
    restart();
    measure(3'd0, n); chk("R4 off 256 x base 1", n, 256);
    // R5: zero recovery length still takes one tick
    rec_len = 8'd0;
    measure(3'd1, n); chk("R5 zero recovery min", n, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule